// File: doc/BRIEF.md
# Indexed Address Bus Sequencer

This block turns one memory-access request of an 8-bit processor into the exact series of bus cycles that the processor's indexed addressing produces, spurious cycles included. A request carries a 16-bit base, an 8-bit index, an addressing mode and an access kind. The block forms the effective address and works out whether adding the index carried out of the low byte. It then drives one bus cycle per clock. Where the access needs one, the first cycle is a dummy read at the uncorrected address: the base's high byte with the summed low byte. The real access follows at the corrected address.

Read-modify-write accesses are replayed as the processor does them. The block reads the byte, writes the unmodified byte back, then writes the modified byte, all at one address. The modified byte comes from an external ALU on `mod_data` during the last write cycle. The ALU takes the old byte straight off `bus_rdata` during the read. Opcode decode and arithmetic are outside this block.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request fields are sampled on that edge. `req_valid` may stay high while the block is busy. Nothing is taken then, and the fields may change freely until `req_ready` returns. The bus side has no back-pressure: every bus cycle lasts exactly one clock.

Top module: `idx_bus_seq`

## Requirements
- R1: The effective address depends on `req_mode`. Mode 2 (indexed) gives base + index modulo 2^16. Mode 1 (zero-page indexed) gives {8'h00, (base[7:0] + index) mod 256}, whatever the base high byte is. Modes 0 and 3 (direct) give the base unchanged. In mode 2 the uncorrected address is {base[15:8], (base[7:0] + index)[7:0]}.
- R2: A load (`req_kind` 0) in mode 2 performs a dummy read at the uncorrected address only when the low-byte addition carries. It then performs one read at the effective address, which is its last cycle.
- R3: A store (`req_kind` 1) in mode 2 always starts with a dummy read at the uncorrected address, even without a carry. It then writes the request's `req_wdata`, sampled at acceptance, at the effective address.
- R4: A read-modify-write (`req_kind` 2) reads the effective address. Next it writes back the byte read in that cycle, then writes `mod_data`, all three at the effective address. In mode 2 a dummy read at the uncorrected address always comes first.
- R5: In modes 0, 1 and 3 no access kind ever produces a dummy read. The first bus cycle is the real access.
- R6: A probe (`req_kind` 3, an addressing-only no-operation) in mode 2 always performs the dummy read at the uncorrected address. It then performs a read at the effective address and never writes.
- R7: Each bus cycle lasts exactly one clock, and `bus_rd` and `bus_wr` are never both high. While the block is idle, and after reset, both strobes and `done` are low, `bus_addr` is 0 and `bus_wdata` is 0 outside write cycles.
- R8: `req_ready` is high exactly when idle. The first bus cycle of an accepted request appears in the clock after acceptance. `done` is high during the last bus cycle only, and `req_ready` is high again in the following clock. `req_valid` and field changes while busy have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 probe |
| req_mode | input | 2 | 0 direct, 1 zero-page indexed, 2 indexed, 3 direct |
| req_base | input | 16 | Base address |
| req_index | input | 8 | Index value added to the base |
| req_wdata | input | 8 | Store data, sampled at acceptance |
| mod_data | input | 8 | Modified byte, used in the final read-modify-write cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data, 0 outside write cycles |
| bus_rdata | input | 8 | Read data returned by memory in the same cycle |
| done | output | 1 | High during the last bus cycle of a request |

## Verification
The assertions take for granted three things about the environment. `bus_rdata` settles within the cycle in which its read strobe is high. `mod_data` is valid in the final read-modify-write cycle. Request fields only need to be meaningful on the accepting edge. The stimulus drives all inputs at the falling edge. A combinational memory model derives each read byte from the address alone, so the written-back byte can be predicted. Some sequences keep `req_valid` high with corrupted fields throughout a busy period, to show that such activity stays outside the sequence.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_RMW   = 2'd2,
    ACC_PROBE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_ZPIDX  = 2'd1,
    AM_IDX    = 2'd2,
    AM_DIR2   = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FIX   = 3'd1,
    PH_READ  = 3'd2,
    PH_STORE = 3'd3,
    PH_WOLD  = 3'd4,
    PH_WNEW  = 3'd5
  } phase_e;

endpackage

// File: rtl/ixs_addr_calc.sv
module ixs_addr_calc
  import idx_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  index,
  input  amode_e            mode,
  output logic [ADDR_W-1:0] eff,
  output logic [ADDR_W-1:0] unfixed,
  output logic              crossed
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [OFS_W:0]    lo_sum;
  logic [ADDR_W-1:0] full_sum;

  // low-byte sum with its carry kept apart from the page number
  assign lo_sum   = {1'b0, base[OFS_W-1:0]} + {1'b0, index};
  assign full_sum = base + {{HI_W{1'b0}}, index};

  always_comb begin
    eff     = base;
    unfixed = base;
    crossed = 1'b0;
    case (mode)
      AM_IDX: begin
        eff     = full_sum;
        unfixed = {base[ADDR_W-1:OFS_W], lo_sum[OFS_W-1:0]};
        crossed = lo_sum[OFS_W];
      end
      AM_ZPIDX: begin
        eff     = {{HI_W{1'b0}}, lo_sum[OFS_W-1:0]};
        unfixed = {{HI_W{1'b0}}, lo_sum[OFS_W-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ixs_phase_fsm.sv
module ixs_phase_fsm
  import idx_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  acc_kind_e kind_in,
  input  logic      need_fix,
  output phase_e    phase,
  output logic      idle,
  output logic      last
);
  phase_e    ph_q, ph_d;
  acc_kind_e kind_q;

  function automatic phase_e first_real(input acc_kind_e k);
    return (k == ACC_STORE) ? PH_STORE : PH_READ;
  endfunction

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:  if (accept) ph_d = need_fix ? PH_FIX : first_real(kind_in);
      PH_FIX:   ph_d = first_real(kind_q);
      PH_READ:  ph_d = (kind_q == ACC_RMW) ? PH_WOLD : PH_IDLE;
      PH_STORE: ph_d = PH_IDLE;
      PH_WOLD:  ph_d = PH_WNEW;
      PH_WNEW:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= ACC_LOAD;
    end else begin
      ph_q <= ph_d;
      if (accept && ph_q == PH_IDLE) kind_q <= kind_in;
    end
  end

  assign phase = ph_q;
  assign idle  = (ph_q == PH_IDLE);
  assign last  = ((ph_q == PH_READ) && (kind_q != ACC_RMW)) ||
                 (ph_q == PH_STORE) || (ph_q == PH_WNEW);

  // R4: the write of the old byte always directly follows the real read
  p_wold_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WOLD) |-> ($past(ph_q) == PH_READ));

  // R2: the dummy read is followed by the real access, never by idle
  p_fix_then_real_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FIX) |=> ((ph_q == PH_READ) || (ph_q == PH_STORE)));

  // R8: last bus cycle is followed by readiness
  p_done_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/ixs_wdata_path.sv
module ixs_wdata_path
  import idx_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] store_in,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] mod_in,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      old_q   <= '0;
    end else begin
      if (accept) store_q <= store_in;
      if (phase == PH_READ) old_q <= rdata;
    end
  end

  always_comb begin
    case (phase)
      PH_STORE: wdata = store_q;
      PH_WOLD:  wdata = old_q;
      PH_WNEW:  wdata = mod_in;
      default:  wdata = '0;
    endcase
  end

  // R4: the first write of a read-modify-write echoes the byte just read
  p_wold_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WOLD) |-> (wdata == $past(rdata)));
endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
  import idx_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mod_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done
);
  acc_kind_e         kind_in;
  amode_e            mode_in;
  logic [ADDR_W-1:0] eff_c, unf_c;
  logic              cross_c;
  logic              need_fix;
  logic              accept;
  logic              idle;
  phase_e            phase;
  logic [ADDR_W-1:0] eff_q, unf_q;

  assign kind_in = acc_kind_e'(req_kind);
  assign mode_in = amode_e'(req_mode);

  ixs_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_calc (
    .base    (req_base),
    .index   (req_index),
    .mode    (mode_in),
    .eff     (eff_c),
    .unfixed (unf_c),
    .crossed (cross_c)
  );

  // loads pay for the dummy read only on a carry; every other kind always does
  assign need_fix = (mode_in == AM_IDX) && ((kind_in != ACC_LOAD) || cross_c);
  assign accept   = req_valid && idle;

  ixs_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .kind_in  (kind_in),
    .need_fix (need_fix),
    .phase    (phase),
    .idle     (idle),
    .last     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
      unf_q <= '0;
    end else if (accept) begin
      eff_q <= eff_c;
      unf_q <= unf_c;
    end
  end

  ixs_wdata_path #(.DATA_W(DATA_W)) u_wdata (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .store_in (req_wdata),
    .phase    (phase),
    .rdata    (bus_rdata),
    .mod_in   (mod_data),
    .wdata    (bus_wdata)
  );

  assign req_ready = idle;
  assign bus_rd    = (phase == PH_FIX) || (phase == PH_READ);
  assign bus_wr    = (phase == PH_STORE) || (phase == PH_WOLD) || (phase == PH_WNEW);

  always_comb begin
    case (phase)
      PH_IDLE: bus_addr = '0;
      PH_FIX:  bus_addr = unf_q;
      default: bus_addr = eff_q;
    endcase
  end

  // R7: one strobe at a time
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R1: a carry from the low byte is exactly a change of page
  p_carry_is_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_in == AM_IDX) |->
      (cross_c == (eff_c[ADDR_W-1:OFS_W] != req_base[ADDR_W-1:OFS_W])));

  // R2: the corrected access keeps the low byte of the dummy read
  p_fix_low_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIX) |=> (bus_addr[OFS_W-1:0] == $past(bus_addr[OFS_W-1:0])));

  // R4: both writes of a read-modify-write target the read address
  p_rmw_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_WOLD) || (phase == PH_WNEW)) |-> $stable(bus_addr));
endmodule

// File: tb/test_idx_bus_seq.sv
`timescale 1ns/1ps
module test_idx_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_mode = '0;
  logic [15:0] req_base = '0;
  logic [7:0]  req_index = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  mod_data = '0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, done;
  logic [7:0]  bus_wdata, bus_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  idx_bus_seq i_idx_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_mode(req_mode), .req_base(req_base),
    .req_index(req_index), .req_wdata(req_wdata), .mod_data(mod_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done)
  );

  // expected cycle: {rd, wr, done, addr, wdata}
  logic [26:0] e_seq [0:4];
  int e_n;

  task automatic check(input string tag, input logic [26:0] got, input logic [26:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%07h expected=%07h", tag, got, exp);
    end
  endtask

  task automatic build(input logic [1:0] k, input logic [1:0] m, input logic [15:0] b,
                       input logic [7:0] ix, input logic [7:0] sd, input logic [7:0] md);
    logic [8:0]  lo;
    logic [15:0] eff, unf;
    bit fix;
    lo = {1'b0, b[7:0]} + {1'b0, ix};
    eff = b; unf = b; fix = 1'b0;
    if (m == 2'd2) begin
      eff = b + {8'h00, ix};
      unf = {b[15:8], lo[7:0]};
      fix = (k != 2'd0) || lo[8];
    end else if (m == 2'd1) begin
      eff = {8'h00, lo[7:0]};
    end
    e_n = 0;
    if (fix) begin e_seq[e_n] = {3'b100, unf, 8'h00}; e_n++; end
    case (k)
      2'd1: begin e_seq[e_n] = {3'b011, eff, sd}; e_n++; end
      2'd2: begin
        e_seq[e_n] = {3'b100, eff, 8'h00}; e_n++;
        e_seq[e_n] = {3'b010, eff, mem_val(eff)}; e_n++;
        e_seq[e_n] = {3'b011, eff, md}; e_n++;
      end
      default: begin e_seq[e_n] = {3'b101, eff, 8'h00}; e_n++; end
    endcase
  endtask

  task automatic run_op(input string tag, input logic [1:0] k, input logic [1:0] m,
                        input logic [15:0] b, input logic [7:0] ix, input logic [7:0] sd,
                        input logic [7:0] md, input bit hold);
    build(k, m, b, ix, sd, md);
    @(negedge clk);
    req_kind = k; req_mode = m; req_base = b; req_index = ix; req_wdata = sd;
    mod_data = md; req_valid = 1'b1;
    check({tag, " R8 ready at accept"}, {26'd0, req_ready}, 27'd1);
    for (int c = 0; c < e_n; c++) begin
      @(negedge clk);
      if (!hold && c == 0) req_valid = 1'b0;
      if (hold && c == 0) begin
        req_base = ~b; req_index = ~ix; req_wdata = ~sd; req_kind = ~k;
      end
      if (hold && c == e_n - 1) req_valid = 1'b0;
      check($sformatf("%s cycle %0d", tag, c), {bus_rd, bus_wr, done, bus_addr, bus_wdata}, e_seq[c]);
      check({tag, " R8 busy not ready"}, {26'd0, req_ready}, 27'd0);
    end
    @(negedge clk);
    check({tag, " R7 R8 idle after"}, {req_ready, bus_rd, bus_wr, done, bus_addr, bus_wdata},
          {1'b1, 3'b000, 16'h0000, 8'h00});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7 reset outputs", {req_ready, bus_rd, bus_wr, done, bus_addr, bus_wdata},
          {1'b1, 3'b000, 16'h0000, 8'h00});
  endtask

  task automatic t_load;
    run_op("R2 R1 load no carry", 2'd0, 2'd2, 16'h1234, 8'h10, 8'h00, 8'h00, 1'b0);
    run_op("R2 R1 load carry", 2'd0, 2'd2, 16'h12F0, 8'h20, 8'h00, 8'h00, 1'b0);
    run_op("R2 R1 load wrap 64k", 2'd0, 2'd2, 16'hFFF0, 8'h20, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_store;
    run_op("R3 store no carry", 2'd1, 2'd2, 16'h2000, 8'h05, 8'hA7, 8'h00, 1'b0);
    run_op("R3 store carry", 2'd1, 2'd2, 16'h20FF, 8'h01, 8'h5E, 8'h00, 1'b0);
  endtask

  task automatic t_rmw;
    run_op("R4 rmw indexed no carry", 2'd2, 2'd2, 16'h4410, 8'h22, 8'h00, 8'hC3, 1'b0);
    run_op("R4 rmw indexed carry", 2'd2, 2'd2, 16'h44E0, 8'h40, 8'h00, 8'h19, 1'b0);
  endtask

  task automatic t_probe;
    run_op("R6 probe no carry", 2'd3, 2'd2, 16'h6000, 8'h01, 8'h00, 8'h00, 1'b0);
    run_op("R6 probe carry", 2'd3, 2'd2, 16'h60FE, 8'h03, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_unindexed;
    run_op("R5 R1 zp load wrap", 2'd0, 2'd1, 16'h45F0, 8'h20, 8'h00, 8'h00, 1'b0);
    run_op("R5 zp store", 2'd1, 2'd1, 16'h0080, 8'h90, 8'h6D, 8'h00, 1'b0);
    run_op("R5 R4 zp rmw", 2'd2, 2'd1, 16'h0010, 8'h01, 8'h00, 8'h77, 1'b0);
    run_op("R5 R4 direct rmw", 2'd2, 2'd0, 16'h3456, 8'hFF, 8'h00, 8'hE1, 1'b0);
    run_op("R5 direct store mode3", 2'd1, 2'd3, 16'h9ABC, 8'h80, 8'h42, 8'h00, 1'b0);
    run_op("R5 direct probe", 2'd3, 2'd0, 16'h0102, 8'hFF, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_busy_valid;
    run_op("R8 valid held rmw", 2'd2, 2'd2, 16'h70F8, 8'h10, 8'h00, 8'h2B, 1'b1);
    run_op("R8 valid held store", 2'd1, 2'd2, 16'h7000, 8'h01, 8'h99, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_load();
    t_store();
    t_rmw();
    t_probe();
    t_unindexed();
    t_busy_valid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog R7 got=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule